// File: doc/BRIEF.md
# Sticky Error Flag Register with Interrupt Mask

This block gathers the error events produced by the bus engine of a serial-bus target controller. Each event arrives as a single-cycle pulse. The block turns it into a flag bit that stays set until software clears it. Some events are accepted only under qualifying conditions before they reach their flag:
- A NACK counts only in I2C mode.
- An unsupported direct command counts only when it is addressed to this target.
- A timeout counts as a hot-join or in-band-interrupt error only if a request of that kind is still waiting for the bus to respond.

Software reaches two 8-bit registers through a single read/write port: the flag register and an enable mask. A single registered interrupt line is raised while any enabled flag is set. The protocol engine, the retry counters and the timeout counters are outside the block and appear only as event inputs.

Top module: `err_flag_regs`

## Requirements
- R1: After reset, all flags and all enable bits read 0 and `irq_o` is 0.
- R2: Each qualified event sets its flag, visible one cycle after the pulse. The bit positions are:
  - bit 7: I2C NACK
  - bit 6: transmit underrun
  - bit 5: receive overrun
  - bit 4: hot-join error
  - bit 3: in-band-interrupt error
  - bit 2: bus protocol error
  - bit 1: bus timeout
  - bit 0: unsupported command
- R3: A set flag stays set through any number of cycles without a flag-register write. It is never cleared by hardware.
- R4: A write with `reg_sel_i`=0 loads all 8 bits of `reg_wdata_i` into the flags. If a hardware set for a bit occurs in the same cycle, the written value is stored and the event is lost.
- R5: A NACK pulse while `mode_i2c_i`=0 leaves bit 7 unchanged.
- R6: An unsupported command sets bit 0 when it is broadcast (`ccc_direct_i`=0). When it is direct, it sets bit 0 only if `ccc_addr_match_i`=1.
- R7: Bit 4 is set when the hot-join retry overflow pulses, or when a timeout pulses while the hot-join pending marker is set.
  - The marker is set in the cycle after `hj_req_i`.
  - It is cleared after `bus_ack_i`, `bus_activity_i` or `timeout_ev_i`.
  - A clearing input in the same cycle as the request wins over the request.
- R8: Bit 3 follows the same rules as R7, using the in-band-interrupt overflow, the `ibi_req_i` request and its own pending marker.
- R9: A timeout with no pending request sets only bit 1.
- R10: A write with `reg_sel_i`=1 loads the enable mask. Reads return the selected register combinationally and have no side effects.
- R11: `irq_o` equals the OR of (flag AND enable) as it was one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 = flags, 1 = enable mask |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| mode_i2c_i | input | 1 | Controller is in I2C mode |
| nack_ev_i | input | 1 | NACK received during transmit |
| tx_underrun_ev_i | input | 1 | No transmit data during a read |
| rx_overrun_ev_i | input | 1 | Received data could not be stored |
| hj_retry_ovf_i | input | 1 | Hot-join retry limit exceeded |
| hj_req_i | input | 1 | Hot-join request issued |
| ibi_retry_ovf_i | input | 1 | In-band-interrupt retry limit exceeded |
| ibi_req_i | input | 1 | In-band-interrupt request issued |
| bus_ack_i | input | 1 | Bus acknowledge seen |
| bus_activity_i | input | 1 | Other bus activity seen |
| timeout_ev_i | input | 1 | Bus timeout |
| proto_err_ev_i | input | 1 | Bus protocol error |
| ccc_unsup_ev_i | input | 1 | Unsupported command received |
| ccc_direct_i | input | 1 | The command is direct, not broadcast |
| ccc_addr_match_i | input | 1 | The direct command addresses this target |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with its default 8-bit flag width. At that width each individual flag position, the all-ones write pattern and the full enable mask can be driven and compared against a behavioural model on every clock. The collision of a write with an event, and a request arriving in the same cycle as its clearing input, are exercised directly. Both pending markers are walked through their set, clear and timeout paths.

// File: rtl/err_flag_pkg.sv
package err_flag_pkg;
  localparam int FLAG_W = 8;
  localparam int N_REQ  = 2;  // hot-join, in-band interrupt

  typedef struct packed {
    logic nack;
    logic tx_udr;
    logic rx_ovr;
    logic hj_err;
    logic ibi_err;
    logic proto_err;
    logic timeout;
    logic ccc_unsup;
  } err_flags_t;
endpackage

// File: rtl/err_req_tracker.sv
module err_req_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic clr_i,
  input  logic timeout_i,
  output logic pend_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pend_q <= 1'b0;
    else if (clr_i || timeout_i) pend_q <= 1'b0;
    else if (req_i)              pend_q <= 1'b1;
  end

  assign pend_o = pend_q;

  // R7
  pend_clr_on_timeout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i |=> !pend_o);
  // R7
  pend_set_on_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !clr_i && !timeout_i) |=> pend_o);
endmodule

// File: rtl/err_event_qual.sv
module err_event_qual
  import err_flag_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_i2c_i,
  input  logic       nack_ev_i,
  input  logic       tx_underrun_ev_i,
  input  logic       rx_overrun_ev_i,
  input  logic       hj_retry_ovf_i,
  input  logic       hj_req_i,
  input  logic       ibi_retry_ovf_i,
  input  logic       ibi_req_i,
  input  logic       bus_ack_i,
  input  logic       bus_activity_i,
  input  logic       timeout_ev_i,
  input  logic       proto_err_ev_i,
  input  logic       ccc_unsup_ev_i,
  input  logic       ccc_direct_i,
  input  logic       ccc_addr_match_i,
  output err_flags_t set_o
);
  logic [N_REQ-1:0] req_v, ovf_v, pend_v, err_v;
  logic             bus_clr;

  assign bus_clr = bus_ack_i | bus_activity_i;
  assign req_v   = {ibi_req_i, hj_req_i};
  assign ovf_v   = {ibi_retry_ovf_i, hj_retry_ovf_i};

  for (genvar g = 0; g < N_REQ; g++) begin : g_req
    err_req_tracker u_trk (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (req_v[g]),
      .clr_i     (bus_clr),
      .timeout_i (timeout_ev_i),
      .pend_o    (pend_v[g])
    );
    assign err_v[g] = ovf_v[g] | (timeout_ev_i & pend_v[g]);
  end

  always_comb begin
    set_o           = '0;
    set_o.nack      = nack_ev_i & mode_i2c_i;
    set_o.tx_udr    = tx_underrun_ev_i;
    set_o.rx_ovr    = rx_overrun_ev_i;
    set_o.hj_err    = err_v[0];
    set_o.ibi_err   = err_v[1];
    set_o.proto_err = proto_err_ev_i;
    set_o.timeout   = timeout_ev_i;
    set_o.ccc_unsup = ccc_unsup_ev_i & (~ccc_direct_i | ccc_addr_match_i);
  end
endmodule

// File: rtl/err_flag_bank.sv
module err_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] flags_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (wr_i)     q <= wdata_i[i];  // software wins
      else if (set_i[i]) q <= 1'b1;
    end
    assign flags_o[i] = q;

    // R3
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_i && flags_o[i]) |=> flags_o[i]);
    // R2
    hw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_i && set_i[i]) |=> flags_o[i]);
    // R4
    sw_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> (flags_o[i] == $past(wdata_i[i])));
  end
endmodule

// File: rtl/err_irq_gen.sv
module err_irq_gen #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] flags_i,
  output logic [W-1:0] en_o,
  output logic         irq_o
);
  logic [W-1:0] en_q;
  logic         irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_i) en_q <= wdata_i;
      irq_q <= |(flags_i & en_q);
    end
  end

  assign en_o  = en_q;
  assign irq_o = irq_q;

  // R10
  en_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (en_o == $past(wdata_i)));
  // R11
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flags_i & en_o) == '0) |=> !irq_o);
endmodule

// File: rtl/err_flag_regs.sv
module err_flag_regs
  import err_flag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [FLAG_W-1:0] reg_wdata_i,
  output logic [FLAG_W-1:0] reg_rdata_o,
  input  logic              mode_i2c_i,
  input  logic              nack_ev_i,
  input  logic              tx_underrun_ev_i,
  input  logic              rx_overrun_ev_i,
  input  logic              hj_retry_ovf_i,
  input  logic              hj_req_i,
  input  logic              ibi_retry_ovf_i,
  input  logic              ibi_req_i,
  input  logic              bus_ack_i,
  input  logic              bus_activity_i,
  input  logic              timeout_ev_i,
  input  logic              proto_err_ev_i,
  input  logic              ccc_unsup_ev_i,
  input  logic              ccc_direct_i,
  input  logic              ccc_addr_match_i,
  output logic              irq_o
);
  err_flags_t        set_s;
  logic [FLAG_W-1:0] flags_s, en_s;
  logic              wr_flags, wr_en;

  assign wr_flags = reg_wr_i & ~reg_sel_i;
  assign wr_en    = reg_wr_i &  reg_sel_i;

  err_event_qual u_qual (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .mode_i2c_i       (mode_i2c_i),
    .nack_ev_i        (nack_ev_i),
    .tx_underrun_ev_i (tx_underrun_ev_i),
    .rx_overrun_ev_i  (rx_overrun_ev_i),
    .hj_retry_ovf_i   (hj_retry_ovf_i),
    .hj_req_i         (hj_req_i),
    .ibi_retry_ovf_i  (ibi_retry_ovf_i),
    .ibi_req_i        (ibi_req_i),
    .bus_ack_i        (bus_ack_i),
    .bus_activity_i   (bus_activity_i),
    .timeout_ev_i     (timeout_ev_i),
    .proto_err_ev_i   (proto_err_ev_i),
    .ccc_unsup_ev_i   (ccc_unsup_ev_i),
    .ccc_direct_i     (ccc_direct_i),
    .ccc_addr_match_i (ccc_addr_match_i),
    .set_o            (set_s)
  );

  err_flag_bank #(.W(FLAG_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_flags),
    .wdata_i (reg_wdata_i),
    .set_i   (set_s),
    .flags_o (flags_s)
  );

  err_irq_gen #(.W(FLAG_W)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en),
    .wdata_i (reg_wdata_i),
    .flags_i (flags_s),
    .en_o    (en_s),
    .irq_o   (irq_o)
  );

  assign reg_rdata_o = reg_sel_i ? en_s : flags_s;

  // R5
  nack_mode_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nack_ev_i && !mode_i2c_i && !wr_flags && !flags_s[7]) |=> !flags_s[7]);
  // R6
  ccc_addr_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ccc_unsup_ev_i && ccc_direct_i && !ccc_addr_match_i && !wr_flags && !flags_s[0])
      |=> !flags_s[0]);
  // R9
  timeout_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_ev_i && !wr_flags) |=> flags_s[1]);
endmodule

// File: tb/err_flag_regs_tb.sv
`timescale 1ns/1ps
module err_flag_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_wr = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       i2c = 0, nack = 0, txu = 0, rxo = 0, hjovf = 0, hjreq = 0;
  logic       ibiovf = 0, ibireq = 0, ack = 0, act = 0, tmo = 0, proto = 0;
  logic       unsup = 0, direct = 0, amatch = 0;
  logic       irq;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0] m_fl = 0, m_en = 0;
  bit m_hp = 0, m_ip = 0, m_irq = 0;

  always #2 clk = ~clk;

  err_flag_regs dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mode_i2c_i(i2c),
    .nack_ev_i(nack), .tx_underrun_ev_i(txu), .rx_overrun_ev_i(rxo),
    .hj_retry_ovf_i(hjovf), .hj_req_i(hjreq), .ibi_retry_ovf_i(ibiovf),
    .ibi_req_i(ibireq), .bus_ack_i(ack), .bus_activity_i(act),
    .timeout_ev_i(tmo), .proto_err_ev_i(proto), .ccc_unsup_ev_i(unsup),
    .ccc_direct_i(direct), .ccc_addr_match_i(amatch), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act_v, input logic [7:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act_v, exp_v, $time);
    end
  endtask

  task automatic clr_pulses();
    reg_wr = 0; nack = 0; txu = 0; rxo = 0; hjovf = 0; hjreq = 0; ibiovf = 0;
    ibireq = 0; ack = 0; act = 0; tmo = 0; proto = 0; unsup = 0;
  endtask

  // Advance one clock: reference model update, then compare at edge+1ns.
  task automatic step(input string tag);
    logic [7:0] s, nfl, nen;
    bit nhp, nip, nirq;
    s = {nack & i2c, txu, rxo, hjovf | (tmo & m_hp), ibiovf | (tmo & m_ip),
         proto, tmo, unsup & (!direct | amatch)};
    nfl  = (reg_wr && !reg_sel) ? reg_wdata : (m_fl | s);
    nen  = (reg_wr &&  reg_sel) ? reg_wdata : m_en;
    nirq = |(m_fl & m_en);
    nhp  = (ack || act || tmo) ? 0 : (hjreq  ? 1 : m_hp);
    nip  = (ack || act || tmo) ? 0 : (ibireq ? 1 : m_ip);
    @(posedge clk);
    #1;
    m_fl = nfl; m_en = nen; m_irq = nirq; m_hp = nhp; m_ip = nip;
    clr_pulses();
    chk(tag, reg_rdata, reg_sel ? m_en : m_fl);
    chk({tag, " irq"}, {7'd0, irq}, {7'd0, m_irq});
  endtask

  task automatic wr_reg(input string tag, input logic sel, input logic [7:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    step(tag);
    reg_sel = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 flags", reg_rdata, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    reg_sel = 1; #1;
    chk("R1 enable", reg_rdata, 8'h00);
    reg_sel = 0;
    @(negedge clk); rst_ni = 1;
    step("R1");

    // R2: each event alone, cleared by write afterwards (R4)
    i2c = 1; nack = 1;   step("R2"); chk("R2 bit7", reg_rdata, 8'h80); wr_reg("R4", 0, 8'h00);
    txu = 1;             step("R2"); chk("R2 bit6", reg_rdata, 8'h40); wr_reg("R4", 0, 8'h00);
    rxo = 1;             step("R2"); chk("R2 bit5", reg_rdata, 8'h20); wr_reg("R4", 0, 8'h00);
    hjovf = 1;           step("R7"); chk("R7 ovf", reg_rdata, 8'h10); wr_reg("R4", 0, 8'h00);
    ibiovf = 1;          step("R8"); chk("R8 ovf", reg_rdata, 8'h08); wr_reg("R4", 0, 8'h00);
    proto = 1;           step("R2"); chk("R2 bit2", reg_rdata, 8'h04); wr_reg("R4", 0, 8'h00);
    tmo = 1;             step("R9"); chk("R9 only bit1", reg_rdata, 8'h02); wr_reg("R4", 0, 8'h00);
    unsup = 1; direct = 0; step("R6"); chk("R6 broadcast", reg_rdata, 8'h01); wr_reg("R4", 0, 8'h00);

    // R5: NACK outside I2C mode ignored
    i2c = 0; nack = 1; step("R5"); step("R5");
    chk("R5 bit7 clear", reg_rdata, 8'h00);

    // R6: direct, other address ignored; own address sets
    unsup = 1; direct = 1; amatch = 0; step("R6"); step("R6");
    chk("R6 direct other", reg_rdata, 8'h00);
    unsup = 1; amatch = 1; step("R6");
    chk("R6 direct match", reg_rdata, 8'h01);
    wr_reg("R4", 0, 8'h00); direct = 0; amatch = 0;

    // R7: request, idle, timeout -> hot-join error + timeout
    hjreq = 1; step("R7"); step("R7"); step("R7");
    tmo = 1; step("R7");
    chk("R7 timeout pending", reg_rdata, 8'h12);
    wr_reg("R4", 0, 8'h00);
    // R7: pending cleared by ack
    hjreq = 1; step("R7"); ack = 1; step("R7"); tmo = 1; step("R7");
    chk("R7 after ack", reg_rdata, 8'h02);
    wr_reg("R4", 0, 8'h00);
    // R7: request with activity in same cycle -> no pending
    hjreq = 1; act = 1; step("R7"); tmo = 1; step("R7");
    chk("R7 req+clear", reg_rdata, 8'h02);
    wr_reg("R4", 0, 8'h00);
    // R8: in-band request then timeout; marker cleared by timeout itself
    ibireq = 1; step("R8"); tmo = 1; step("R8");
    chk("R8 timeout pending", reg_rdata, 8'h0A);
    wr_reg("R4", 0, 8'h00);
    tmo = 1; step("R8");
    chk("R8 second timeout", reg_rdata, 8'h02);
    wr_reg("R4", 0, 8'h00);

    // R3: all set, long idle
    i2c = 1; nack = 1; txu = 1; rxo = 1; hjovf = 1; ibiovf = 1; proto = 1; tmo = 1; unsup = 1;
    step("R3");
    for (int k = 0; k < 60; k++) step("R3");
    chk("R3 sticky", reg_rdata, 8'hFF);

    // R4: write collides with events
    reg_wr = 1; reg_sel = 0; reg_wdata = 8'h00; txu = 1; proto = 1;
    step("R4"); chk("R4 collision", reg_rdata, 8'h00);
    reg_wr = 1; reg_wdata = 8'h5A; rxo = 1; step("R4");
    chk("R4 pattern", reg_rdata, 8'h5A);

    // R10/R11: enable mask and interrupt
    wr_reg("R10", 1, 8'h01);
    reg_sel = 1; #1; chk("R10 enable read", reg_rdata, 8'h01); reg_sel = 0;
    step("R11"); chk("R11 masked", {7'd0, irq}, 8'h00);
    unsup = 1; step("R11"); step("R11");
    chk("R11 irq high", {7'd0, irq}, 8'h01);
    wr_reg("R11", 0, 8'h00); step("R11");
    chk("R11 irq low", {7'd0, irq}, 8'h00);
    wr_reg("R10", 1, 8'hFF); rxo = 1; step("R11"); step("R11");
    chk("R11 full mask", {7'd0, irq}, 8'h01);
    reg_sel = 1; step("R10"); step("R10"); reg_sel = 0; step("R10");
    chk("R10 read no side effect", reg_rdata, 8'h20);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule